// File: doc/BRIEF.md
# Transport Stream Ring Buffer Writer

This block takes a byte-wide MPEG transport stream and stores it in a circular buffer in memory. It finds the start of each packet from a start flag and the 0x47 sync byte, and counts a programmable number of bytes per packet. It packs the stream into 32-bit little-endian words and issues them on a simple memory write port. The buffer is defined by a start address and a length in bytes. When the write pointer reaches the end of that region it goes back to the start.

Software reads the write pointer as an absolute address and subtracts the start address to find how much data has arrived. The block counts complete packets and sets a status bit each time the count reaches a programmed threshold. That bit drives the interrupt line when it is unmasked, and software clears it by writing 1. A sticky flag reports packets that did not begin with the sync byte. If software sees that sync has been lost, it pulses a restart input. The restart moves the pointer back to the start of the ring and resets the framing and the packet count.

Top module: `ring_ts_writer`

## Requirements
- R1: After reset, memWe, irq, irqStatus and syncErr are 0 and wrPtr equals ringStart.
- R2: A packet begins only on a valid byte with tsSop high and value 0x47. Valid bytes seen outside a packet without such a start produce no memory write.
- R3: A byte with tsSop high outside a packet whose value is not 0x47 is dropped together with the rest of its packet. It also sets syncErr, which stays 1 until restart.
- R4: Within a packet, byte k (k counted from 0) goes to bits 8*(k mod 4)+7 down to 8*(k mod 4) of a 32-bit word. memWe is high for exactly the one cycle after the clock edge that takes the fourth byte of the word, and in that cycle memAddr is the wrPtr value from before the write.
- R5: wrPtr is an absolute byte address. It starts at ringStart and advances by 4 with every word written.
- R6: After a word is written at ringStart+ringLen-4, wrPtr returns to ringStart. ringLen is a multiple of 4.
- R7: A packet ends after pktLen bytes (a multiple of 4). Valid bytes that follow it produce no memory write until the next good packet start.
- R8: The block counts completed packets. irqStatus is set on the edge that completes the packet which makes the count equal pktsPerIrq, and the count then restarts from 0.
- R9: irq equals irqStatus AND irqMask AND enable. A cycle with irqAck high clears irqStatus, unless the status is being set in that same cycle.
- R10: A restart pulse sets wrPtr to ringStart on the next edge. It also clears the packet count, abandons any partial packet and clears syncErr.
- R11: While enable is low, incoming bytes are discarded and any partial packet is abandoned. Bytes that arrive after enable returns produce no write until a new packet start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Global enable for capture and interrupt |
| tsData | input | 8 | Stream byte |
| tsValid | input | 1 | Stream byte valid |
| tsSop | input | 1 | Marks the first byte of a packet |
| pktLen | input | LEN_W | Bytes per packet |
| ringStart | input | ADDR_W | Ring base byte address |
| ringLen | input | ADDR_W | Ring size in bytes |
| pktsPerIrq | input | CNT_W | Packets per interrupt event |
| restart | input | 1 | Restart pulse for pointer and framing |
| irqMask | input | 1 | Interrupt enable for the stream event |
| irqAck | input | 1 | Write-one-to-clear for irqStatus |
| memAddr | output | ADDR_W | Memory write byte address |
| memData | output | 32 | Memory write word |
| memWe | output | 1 | Memory write enable |
| wrPtr | output | ADDR_W | Current absolute write address |
| irq | output | 1 | Interrupt line |
| irqStatus | output | 1 | Sticky stream-event status |
| syncErr | output | 1 | Sticky sync-error flag |

## Verification
The bench uses the default widths: a 32-bit address, a 9-bit length field and an 8-bit count. Most scenarios run with 8-byte packets, a 24-byte ring at 0x100 and an interrupt every 2 packets. With these values a ring wrap, an interrupt and a sync error each happen within a few dozen bytes, and every pointer position can be checked. One scenario switches to 188-byte packets in a 1024-byte ring. This checks the full-length packet count and the pointer after 47 words.

// File: rtl/ring_ts_pkg.sv
package ring_ts_pkg;
  localparam logic [7:0] SYNC_BYTE = 8'h47;

  typedef struct packed {
    logic       take;      // byte accepted into the current word
    logic [1:0] lane;      // byte lane in the word
    logic       wordDone;  // fourth byte of a word accepted
    logic       restart;   // pointer back to ring start
  } ringStrobe_t;
endpackage

// File: rtl/ring_ts_ctrl.sv
module ring_ts_ctrl
  import ring_ts_pkg::*;
#(
  parameter int LEN_W = 9,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [7:0]       tsData,
  input  logic             tsValid,
  input  logic             tsSop,
  input  logic [LEN_W-1:0] pktLen,
  input  logic [CNT_W-1:0] pktsPerIrq,
  input  logic             restart,
  input  logic             irqAck,
  output ringStrobe_t      stb,
  output logic             irqStatus,
  output logic             syncErr
);
  logic             inPkt;
  logic [LEN_W-1:0] byteCnt;
  logic [CNT_W-1:0] pktCnt;
  logic             startOk;
  logic             startBad;
  logic             lastByte;
  logic             hitThresh;

  assign startOk   = enable && tsValid && !inPkt && tsSop && (tsData == SYNC_BYTE);
  assign startBad  = enable && tsValid && !inPkt && tsSop && (tsData != SYNC_BYTE);
  assign lastByte  = stb.take && ((byteCnt + 1'b1) >= pktLen);
  assign hitThresh = lastByte && ((pktCnt + 1'b1) >= pktsPerIrq);

  always_comb begin
    stb.restart  = restart;
    stb.take     = !restart && (startOk || (enable && tsValid && inPkt));
    stb.lane     = byteCnt[1:0];
    stb.wordDone = stb.take && (byteCnt[1:0] == 2'd3);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inPkt     <= 1'b0;
      byteCnt   <= '0;
      pktCnt    <= '0;
      irqStatus <= 1'b0;
      syncErr   <= 1'b0;
    end else begin
      if (restart) begin
        inPkt   <= 1'b0;
        byteCnt <= '0;
        pktCnt  <= '0;
        syncErr <= 1'b0;
      end else if (!enable) begin
        inPkt   <= 1'b0;
        byteCnt <= '0;
      end else begin
        if (startBad) syncErr <= 1'b1;
        if (lastByte) begin
          inPkt   <= 1'b0;
          byteCnt <= '0;
          pktCnt  <= hitThresh ? '0 : pktCnt + 1'b1;
        end else if (stb.take) begin
          inPkt   <= 1'b1;
          byteCnt <= byteCnt + 1'b1;
        end
      end
      if (hitThresh && !restart) irqStatus <= 1'b1;
      else if (irqAck)           irqStatus <= 1'b0;
    end
  end
endmodule

// File: rtl/ring_ts_dpath.sv
module ring_ts_dpath
  import ring_ts_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStrobe_t       stb,
  input  logic [7:0]        tsData,
  input  logic [ADDR_W-1:0] ringStart,
  input  logic [ADDR_W-1:0] ringLen,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memData,
  output logic              memWe,
  output logic [ADDR_W-1:0] wrPtr
);
  localparam int LANES = 4;
  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(LANES);

  logic [7:0]        laneBuf [LANES-1];
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] nextOff;

  assign wrPtr   = ringStart + offset;
  assign nextOff = ((offset + WORD_BYTES) >= ringLen) ? '0 : offset + WORD_BYTES;

  for (genvar g = 0; g < LANES - 1; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN) laneBuf[g] <= '0;
      else if (stb.take && (stb.lane == 2'(g))) laneBuf[g] <= tsData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offset  <= '0;
      memWe   <= 1'b0;
      memAddr <= '0;
      memData <= '0;
    end else begin
      memWe <= 1'b0;
      if (stb.restart) begin
        offset <= '0;
      end else if (stb.wordDone) begin
        memWe   <= 1'b1;
        memAddr <= wrPtr;
        memData <= {tsData, laneBuf[2], laneBuf[1], laneBuf[0]};
        offset  <= nextOff;
      end
    end
  end
endmodule

// File: rtl/ring_ts_writer.sv
module ring_ts_writer
  import ring_ts_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 9,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [7:0]        tsData,
  input  logic              tsValid,
  input  logic              tsSop,
  input  logic [LEN_W-1:0]  pktLen,
  input  logic [ADDR_W-1:0] ringStart,
  input  logic [ADDR_W-1:0] ringLen,
  input  logic [CNT_W-1:0]  pktsPerIrq,
  input  logic              restart,
  input  logic              irqMask,
  input  logic              irqAck,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memData,
  output logic              memWe,
  output logic [ADDR_W-1:0] wrPtr,
  output logic              irq,
  output logic              irqStatus,
  output logic              syncErr
);
  ringStrobe_t stb;

  ring_ts_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .tsData(tsData),
    .tsValid(tsValid), .tsSop(tsSop), .pktLen(pktLen),
    .pktsPerIrq(pktsPerIrq), .restart(restart), .irqAck(irqAck),
    .stb(stb), .irqStatus(irqStatus), .syncErr(syncErr)
  );

  ring_ts_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .tsData(tsData),
    .ringStart(ringStart), .ringLen(ringLen), .memAddr(memAddr),
    .memData(memData), .memWe(memWe), .wrPtr(wrPtr)
  );

  assign irq = irqStatus && irqMask && enable;
endmodule

// File: rtl/ring_ts_writer_chk.sv
module ring_ts_writer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              restart,
  input logic              irqMask,
  input logic [ADDR_W-1:0] ringStart,
  input logic [ADDR_W-1:0] ringLen,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memWe,
  input logic [ADDR_W-1:0] wrPtr,
  input logic              irq,
  input logic              irqStatus,
  input logic              syncErr
);
  // R6
  addr_in_ring_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $stable(ringStart) && $stable(ringLen)) |-> ((memAddr - ringStart) < ringLen));

  // R10
  restart_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (restart && !$past(restart) && $stable(ringStart)) |=> (wrPtr == ringStart));

  // R11
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !memWe);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (irqStatus && irqMask && enable));

  // R3
  sync_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncErr && !restart) |=> syncErr);

  // R4
  single_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);
endmodule

bind ring_ts_writer ring_ts_writer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .restart(restart),
  .irqMask(irqMask), .ringStart(ringStart), .ringLen(ringLen),
  .memAddr(memAddr), .memWe(memWe), .wrPtr(wrPtr), .irq(irq),
  .irqStatus(irqStatus), .syncErr(syncErr)
);

// File: tb/tb_ring_ts_writer.sv
`timescale 1ns/1ps
module tb_ring_ts_writer;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 9;
  localparam int CNT_W  = 8;
  localparam logic [31:0] BASE = 32'h100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [7:0] tsData = '0;
  logic tsValid = 1'b0;
  logic tsSop = 1'b0;
  logic [LEN_W-1:0] pktLen = 9'd8;
  logic [ADDR_W-1:0] ringStart = BASE;
  logic [ADDR_W-1:0] ringLen = 32'd24;
  logic [CNT_W-1:0] pktsPerIrq = 8'd2;
  logic restart = 1'b0;
  logic irqMask = 1'b1;
  logic irqAck = 1'b0;
  logic [ADDR_W-1:0] memAddr;
  logic [31:0] memData;
  logic memWe;
  logic [ADDR_W-1:0] wrPtr;
  logic irq, irqStatus, syncErr;

  always #2.5 clk = ~clk;

  ring_ts_writer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .enable(enable), .tsData(tsData),
    .tsValid(tsValid), .tsSop(tsSop), .pktLen(pktLen), .ringStart(ringStart),
    .ringLen(ringLen), .pktsPerIrq(pktsPerIrq), .restart(restart),
    .irqMask(irqMask), .irqAck(irqAck), .memAddr(memAddr), .memData(memData),
    .memWe(memWe), .wrPtr(wrPtr), .irq(irq), .irqStatus(irqStatus),
    .syncErr(syncErr)
  );

  int nTests = 0;
  int nFail = 0;
  logic [31:0] expPtr;
  int logCnt = 0;
  logic [31:0] logAddr [0:63];
  logic [31:0] logData [0:63];

  always @(negedge clk) begin
    if (memWe && logCnt < 64) begin
      logAddr[logCnt] = memAddr;
      logData[logCnt] = memData;
      logCnt = logCnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sendByte(input logic [7:0] d, input logic s);
    tsData = d; tsValid = 1'b1; tsSop = s;
    @(posedge clk); #1;
    tsValid = 1'b0; tsSop = 1'b0;
  endtask

  function automatic logic [7:0] pktByte(input logic [7:0] first, input logic [7:0] seed, input int j);
    return (j == 0) ? first : 8'(seed + j);
  endfunction

  function automatic logic [31:0] nextPtr(input logic [31:0] p);
    return ((p + 4) >= ringStart + ringLen) ? ringStart : p + 4;
  endfunction

  task automatic sendPkt(input logic [7:0] first, input logic [7:0] seed, input int n);
    for (int j = 0; j < n; j++) sendByte(pktByte(first, seed, j), j == 0);
  endtask

  // compares nWords log entries from idx against a good packet; advances expPtr
  task automatic checkWords(input int idx, input logic [7:0] seed, input int nWords, input string req);
    for (int w = 0; w < nWords; w++) begin
      logic [31:0] ew;
      for (int b = 0; b < 4; b++) ew[8*b +: 8] = pktByte(8'h47, seed, 4*w + b);
      chk(logAddr[idx+w] == expPtr, req, logAddr[idx+w], expPtr);
      chk(logData[idx+w] == ew, req, logData[idx+w], ew);
      expPtr = nextPtr(expPtr);
    end
  endtask

  task automatic t_reset();
    chk(memWe == 1'b0, "R1 memWe", 32'(memWe), 0);
    chk({irq, irqStatus, syncErr} == 3'b0, "R1 flags", 32'({irq, irqStatus, syncErr}), 0);
    chk(wrPtr == BASE, "R1 wrPtr", wrPtr, BASE);
    expPtr = BASE;
  endtask

  task automatic t_basic();
    logCnt = 0;
    for (int i = 0; i < 6; i++) sendByte(8'h47, 1'b0); // no start flag: R2
    idle(2);
    chk(logCnt == 0, "R2 stray bytes", logCnt, 0);
    // exact-cycle check of the first word (R4)
    for (int j = 0; j < 4; j++) sendByte(pktByte(8'h47, 8'h10, j), j == 0);
    chk(memWe == 1'b1, "R4 memWe timing", 32'(memWe), 1);
    chk(memAddr == BASE, "R4 memAddr", memAddr, BASE);
    for (int j = 4; j < 8; j++) sendByte(pktByte(8'h47, 8'h10, j), 1'b0);
    idle(2);
    chk(logCnt == 2, "R4 word count", logCnt, 2);
    checkWords(0, 8'h10, 2, "R4 packing");
    chk(wrPtr == BASE + 8, "R5 wrPtr", wrPtr, BASE + 8);
    chk(irqStatus == 1'b0, "R8 below threshold", 32'(irqStatus), 0);
    for (int i = 0; i < 5; i++) sendByte(8'hA0 + 8'(i), 1'b0); // R7 trailing bytes
    idle(2);
    chk(logCnt == 2, "R7 trailing bytes", logCnt, 2);
    sendPkt(8'h47, 8'h20, 8);
    idle(2);
    checkWords(2, 8'h20, 2, "R5 second packet");
    chk(irqStatus == 1'b1, "R8 threshold", 32'(irqStatus), 1);
    chk(irq == 1'b1, "R9 irq", 32'(irq), 1);
  endtask

  task automatic t_irq();
    irqMask = 1'b0; idle(1);
    chk(irq == 1'b0 && irqStatus == 1'b1, "R9 masked", 32'({irq, irqStatus}), 32'b01);
    irqMask = 1'b1; irqAck = 1'b1; idle(1); irqAck = 1'b0; idle(1);
    chk(irqStatus == 1'b0 && irq == 1'b0, "R9 ack", 32'({irq, irqStatus}), 0);
  endtask

  task automatic t_wrap();
    logCnt = 0;
    sendPkt(8'h47, 8'h30, 8);
    idle(2);
    checkWords(0, 8'h30, 2, "R6 words before wrap");
    chk(wrPtr == BASE, "R6 wrap", wrPtr, BASE);
  endtask

  task automatic t_sync();
    logCnt = 0;
    sendPkt(8'h46, 8'h40, 8);
    idle(2);
    chk(logCnt == 0, "R3 dropped", logCnt, 0);
    chk(syncErr == 1'b1, "R3 syncErr set", 32'(syncErr), 1);
    sendPkt(8'h47, 8'h50, 8);
    idle(2);
    checkWords(0, 8'h50, 2, "R3 next good packet");
    chk(syncErr == 1'b1, "R3 sticky", 32'(syncErr), 1);
    irqAck = 1'b1; idle(1); irqAck = 1'b0; idle(1);
  endtask

  task automatic t_restart();
    sendPkt(8'h47, 8'h60, 8);  // count now 1
    for (int j = 0; j < 5; j++) sendByte(pktByte(8'h47, 8'h70, j), j == 0);
    restart = 1'b1; idle(1); restart = 1'b0; idle(1);
    chk(wrPtr == BASE, "R10 wrPtr", wrPtr, BASE);
    chk(syncErr == 1'b0, "R10 syncErr", 32'(syncErr), 0);
    expPtr = BASE;
    logCnt = 0;
    for (int j = 5; j < 8; j++) sendByte(8'h47, 1'b0); // leftovers of abandoned packet
    sendPkt(8'h47, 8'h80, 8);
    idle(2);
    checkWords(0, 8'h80, 2, "R10 framing");
    chk(irqStatus == 1'b0, "R10 count cleared", 32'(irqStatus), 0);
    sendPkt(8'h47, 8'h90, 8);
    idle(2);
    checkWords(2, 8'h90, 2, "R10 second");
    chk(irqStatus == 1'b1, "R8 after restart", 32'(irqStatus), 1);
    irqAck = 1'b1; idle(1); irqAck = 1'b0; idle(1);
  endtask

  task automatic t_disable();
    logCnt = 0;
    enable = 1'b0;
    sendPkt(8'h47, 8'hA0, 8);
    idle(2);
    chk(logCnt == 0, "R11 disabled", logCnt, 0);
    enable = 1'b1;
    for (int j = 0; j < 4; j++) sendByte(pktByte(8'h47, 8'hB0, j), j == 0);
    enable = 1'b0; idle(1); enable = 1'b1;
    for (int j = 4; j < 8; j++) sendByte(pktByte(8'h47, 8'hB0, j), 1'b0);
    idle(2);
    chk(logCnt == 1, "R11 partial abandoned", logCnt, 1);
    checkWords(0, 8'hB0, 1, "R11 first word");
    sendPkt(8'h47, 8'hC0, 8);
    idle(2);
    checkWords(1, 8'hC0, 2, "R11 resume");
  endtask

  task automatic t_long();
    pktLen = 9'd188; ringLen = 32'd1024;
    restart = 1'b1; idle(1); restart = 1'b0; idle(1);
    logCnt = 0;
    sendPkt(8'h47, 8'h00, 188);
    idle(2);
    chk(logCnt == 47, "R7 188-byte words", logCnt, 47);
    chk(wrPtr == BASE + 188, "R5 188-byte pointer", wrPtr, BASE + 188);
  endtask

  bit done = 1'b0;
  initial begin
    #200000;
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    t_reset();
    enable = 1'b1;
    t_basic();
    t_irq();
    t_wrap();
    t_sync();
    t_restart();
    t_disable();
    t_long();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule